// File: doc/BRIEF.md
# Programmable Display Sync Timing Generator

This block produces the raster timing for a display: horizontal sync, vertical sync, blanking and data-enable, plus the coordinates of the pixel currently in the visible window. Timing is programmed as absolute counter positions counted from the start of sync, not as separate lengths. For each axis four positions are given: the end of sync (equal to the sync length), the start of the active window (sync end plus back porch), the end of the active window (active start plus active size) and the total (active end plus front porch). A pixel counter runs through the line and a line counter runs through the frame. The line counter steps each time the pixel counter wraps.

Two more programmable line numbers produce single-cycle pulses at the first pixel of their line. One is a vertical event used as an interrupt, normally set to the first line after the active window. The other is a fetch request, normally set to the vertical sync-end line. Each of the horizontal sync, vertical sync and blank outputs has its own polarity bit. A run enable gates the whole block. While it is low, the counters are held at the origin and every output sits at its inactive level. When it rises, timing restarts at the first pixel of the first line.

Programmed values are copied into shadow registers. While the block runs, the copy is taken only at the frame boundary, so a frame never mixes two timings. While the block is stopped, the copy is taken every cycle. After reset the shadow holds a 640x480 mode: 800 pixels per line, 525 lines, sync lengths 96 and 2, back porches 48 and 33, both syncs high-active and blank high-active.

Top module: `disp_timing_gen`

## Requirements
- R1: While rst_n is low, and for two clock edges after it rises (the reset is released through a two-stage synchronizer), the outputs are hsync=0, vsync=0, blank=1, de=0, pix_x=0, pix_y=0, vevent_irq=0 and vfetch_req=0.
- R2: While enabled, the outputs after enabled edge k show pixel position k-1 of the line (position 0 first). The line has h_total pixels, and hsync is active for positions 0 up to cfg_h_sync_end-1.
- R3: The line number advances when the pixel position wraps, and the frame has v_total lines. vsync is active on lines 0 up to cfg_v_sync_end-1, for whole lines.
- R4: de is 1 exactly when the pixel position is in [h_act_start, h_act_end) and the line is in [v_act_start, v_act_end). blank is at its active level exactly when de is 0.
- R5: While de is 1, pix_x equals the pixel position minus h_act_start and pix_y equals the line minus v_act_start. While de is 0, both are 0.
- R6: vevent_irq is high for exactly one cycle, at pixel position 0 of line cfg_v_event_line.
- R7: vfetch_req is high for exactly one cycle, at pixel position 0 of line cfg_v_fetch_line.
- R8: For cfg_hs_pol, cfg_vs_pol and cfg_blank_pol, the value 1 makes the output high when active and the value 0 makes it low when active.
- R9: A clock edge with sg_en low returns both counters to 0. It sets hsync to the inverse of cfg_hs_pol, vsync to the inverse of cfg_vs_pol and blank to cfg_blank_pol, and sets de, pix_x, pix_y and both pulses to 0. The first enabled edge after that presents position 0 of line 0.
- R10: A configuration change made while running has no effect until pixel 0 of line 0 of the next frame. While stopped, the configuration in force at the first enabled edge is used.
- R11: If the block is enabled straight out of reset, the first frame uses the built-in mode: 800-pixel lines with hsync high for 96 cycles, whatever the configuration inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sg_en | input | 1 | Run enable for the timing generator |
| cfg_h_sync_end | input | 12 | Horizontal sync end position |
| cfg_h_act_start | input | 12 | First active pixel position |
| cfg_h_act_end | input | 12 | First pixel position after the active window |
| cfg_h_total | input | 12 | Pixels per line |
| cfg_v_sync_end | input | 12 | Vertical sync end line |
| cfg_v_act_start | input | 12 | First active line |
| cfg_v_act_end | input | 12 | First line after the active window |
| cfg_v_total | input | 12 | Lines per frame |
| cfg_v_event_line | input | 12 | Line of the vertical event pulse |
| cfg_v_fetch_line | input | 12 | Line of the fetch request pulse |
| cfg_hs_pol | input | 1 | 1 = hsync active high |
| cfg_vs_pol | input | 1 | 1 = vsync active high |
| cfg_blank_pol | input | 1 | 1 = blank active high |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | Blanking |
| de | output | 1 | Data enable |
| pix_x | output | 12 | Active-window column |
| pix_y | output | 12 | Active-window row |
| vevent_irq | output | 1 | Vertical event pulse |
| vfetch_req | output | 1 | Vertical fetch pulse |

## Verification
The bench first runs the built-in mode out of reset. This shows whether the shadow reset values, rather than the inputs, drive the first frame. It then draws random short timings with random polarities and pulse lines. These expose off-by-one errors at every window edge and at the polarity inversion. Reprogramming in the middle of a frame tells whether the shadow copy happens at the frame boundary or earlier. Stop and restart sequences, a zero back porch and pulse lines at the first and last line of the frame cover the edges of the counters.

// File: rtl/tg_pkg.sv
package tg_pkg;
  parameter int unsigned TG_POS_W = 12;

  typedef logic [TG_POS_W-1:0] tg_pos_t;

  typedef struct packed {
    tg_pos_t h_sync_end;
    tg_pos_t h_act_start;
    tg_pos_t h_act_end;
    tg_pos_t h_total;
    tg_pos_t v_sync_end;
    tg_pos_t v_act_start;
    tg_pos_t v_act_end;
    tg_pos_t v_total;
    tg_pos_t v_event_line;
    tg_pos_t v_fetch_line;
    logic    hs_pol;
    logic    vs_pol;
    logic    blank_pol;
  } tg_cfg_t;

  // output level of a signal for a given active state and polarity bit
  function automatic logic tg_level(input logic active, input logic pol);
    return active ? pol : ~pol;
  endfunction
endpackage

// File: rtl/tg_rst_sync.sv
module tg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tg_cfg_shadow.sv
module tg_cfg_shadow
  import tg_pkg::*;
#(
  parameter tg_cfg_t RST_CFG = '0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  tg_cfg_t cfg_in,
  output tg_cfg_t cfg_q
);
  tg_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= RST_CFG;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/tg_axis_cnt.sv
module tg_axis_cnt
  import tg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    adv,
  input  tg_pos_t total,
  output tg_pos_t cnt,
  output logic    at_last
);
  tg_pos_t cnt_d;

  // a total of 0 or 1 both give a one-position axis
  always_comb begin
    at_last = (cnt >= (total - tg_pos_t'(1))) || (total == '0);
    cnt_d   = cnt;
    if (clr)          cnt_d = '0;
    else if (adv) begin
      if (at_last)    cnt_d = '0;
      else            cnt_d = cnt + tg_pos_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/tg_axis_decode.sv
module tg_axis_decode
  import tg_pkg::*;
(
  input  tg_pos_t cnt,
  input  tg_pos_t sync_end,
  input  tg_pos_t act_start,
  input  tg_pos_t act_end,
  output logic    in_sync,
  output logic    in_act,
  output tg_pos_t offs
);
  always_comb begin
    in_sync = cnt < sync_end;
    in_act  = (cnt >= act_start) && (cnt < act_end);
    offs    = cnt - act_start;
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import tg_pkg::*;
#(
  parameter int unsigned DEF_H_SYNC  = 96,
  parameter int unsigned DEF_H_BACK  = 48,
  parameter int unsigned DEF_H_ACT   = 640,
  parameter int unsigned DEF_H_FRONT = 16,
  parameter int unsigned DEF_V_SYNC  = 2,
  parameter int unsigned DEF_V_BACK  = 33,
  parameter int unsigned DEF_V_ACT   = 480,
  parameter int unsigned DEF_V_FRONT = 10,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sg_en,
  input  logic [TG_POS_W-1:0] cfg_h_sync_end,
  input  logic [TG_POS_W-1:0] cfg_h_act_start,
  input  logic [TG_POS_W-1:0] cfg_h_act_end,
  input  logic [TG_POS_W-1:0] cfg_h_total,
  input  logic [TG_POS_W-1:0] cfg_v_sync_end,
  input  logic [TG_POS_W-1:0] cfg_v_act_start,
  input  logic [TG_POS_W-1:0] cfg_v_act_end,
  input  logic [TG_POS_W-1:0] cfg_v_total,
  input  logic [TG_POS_W-1:0] cfg_v_event_line,
  input  logic [TG_POS_W-1:0] cfg_v_fetch_line,
  input  logic                cfg_hs_pol,
  input  logic                cfg_vs_pol,
  input  logic                cfg_blank_pol,
  output logic                hsync,
  output logic                vsync,
  output logic                blank,
  output logic                de,
  output logic [TG_POS_W-1:0] pix_x,
  output logic [TG_POS_W-1:0] pix_y,
  output logic                vevent_irq,
  output logic                vfetch_req
);
  // cumulative default positions
  localparam int unsigned D_HSE = DEF_H_SYNC;
  localparam int unsigned D_HAS = D_HSE + DEF_H_BACK;
  localparam int unsigned D_HAE = D_HAS + DEF_H_ACT;
  localparam int unsigned D_HT  = D_HAE + DEF_H_FRONT;
  localparam int unsigned D_VSE = DEF_V_SYNC;
  localparam int unsigned D_VAS = D_VSE + DEF_V_BACK;
  localparam int unsigned D_VAE = D_VAS + DEF_V_ACT;
  localparam int unsigned D_VT  = D_VAE + DEF_V_FRONT;

  localparam tg_cfg_t RST_CFG = '{
    h_sync_end:   tg_pos_t'(D_HSE),
    h_act_start:  tg_pos_t'(D_HAS),
    h_act_end:    tg_pos_t'(D_HAE),
    h_total:      tg_pos_t'(D_HT),
    v_sync_end:   tg_pos_t'(D_VSE),
    v_act_start:  tg_pos_t'(D_VAS),
    v_act_end:    tg_pos_t'(D_VAE),
    v_total:      tg_pos_t'(D_VT),
    v_event_line: tg_pos_t'(D_VAE),
    v_fetch_line: tg_pos_t'(D_VSE),
    hs_pol:       1'b1,
    vs_pol:       1'b1,
    blank_pol:    1'b1
  };

  logic    rst_sync_n;
  tg_cfg_t cfg_in;
  tg_cfg_t sh_cfg;
  logic    shadow_load;
  logic    frame_wrap;
  tg_pos_t hcnt, vcnt;
  logic    h_last, v_last;
  logic    h_sync_a, h_act_a, v_sync_a, v_act_a;
  tg_pos_t h_offs, v_offs;

  // next values of the output registers
  logic    hsync_d, vsync_d, blank_d, de_d, vevent_d, vfetch_d;
  tg_pos_t pix_x_d, pix_y_d;

  tg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    cfg_in.h_sync_end   = cfg_h_sync_end;
    cfg_in.h_act_start  = cfg_h_act_start;
    cfg_in.h_act_end    = cfg_h_act_end;
    cfg_in.h_total      = cfg_h_total;
    cfg_in.v_sync_end   = cfg_v_sync_end;
    cfg_in.v_act_start  = cfg_v_act_start;
    cfg_in.v_act_end    = cfg_v_act_end;
    cfg_in.v_total      = cfg_v_total;
    cfg_in.v_event_line = cfg_v_event_line;
    cfg_in.v_fetch_line = cfg_v_fetch_line;
    cfg_in.hs_pol       = cfg_hs_pol;
    cfg_in.vs_pol       = cfg_vs_pol;
    cfg_in.blank_pol    = cfg_blank_pol;
  end

  // frame boundary: last pixel of last line while running
  assign frame_wrap  = sg_en && h_last && v_last;
  assign shadow_load = !sg_en || frame_wrap;

  tg_cfg_shadow #(.RST_CFG(RST_CFG)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (shadow_load),
    .cfg_in (cfg_in),
    .cfg_q  (sh_cfg)
  );

  tg_axis_cnt u_hcnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (!sg_en),
    .adv     (sg_en),
    .total   (sh_cfg.h_total),
    .cnt     (hcnt),
    .at_last (h_last)
  );

  tg_axis_cnt u_vcnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (!sg_en),
    .adv     (sg_en && h_last),
    .total   (sh_cfg.v_total),
    .cnt     (vcnt),
    .at_last (v_last)
  );

  tg_axis_decode u_hdec (
    .cnt       (hcnt),
    .sync_end  (sh_cfg.h_sync_end),
    .act_start (sh_cfg.h_act_start),
    .act_end   (sh_cfg.h_act_end),
    .in_sync   (h_sync_a),
    .in_act    (h_act_a),
    .offs      (h_offs)
  );

  tg_axis_decode u_vdec (
    .cnt       (vcnt),
    .sync_end  (sh_cfg.v_sync_end),
    .act_start (sh_cfg.v_act_start),
    .act_end   (sh_cfg.v_act_end),
    .in_sync   (v_sync_a),
    .in_act    (v_act_a),
    .offs      (v_offs)
  );

  // output next-state
  always_comb begin
    logic act;
    act = h_act_a && v_act_a;
    if (!sg_en) begin
      hsync_d  = tg_level(1'b0, cfg_hs_pol);
      vsync_d  = tg_level(1'b0, cfg_vs_pol);
      blank_d  = tg_level(1'b1, cfg_blank_pol);
      de_d     = 1'b0;
      pix_x_d  = '0;
      pix_y_d  = '0;
      vevent_d = 1'b0;
      vfetch_d = 1'b0;
    end else begin
      hsync_d  = tg_level(h_sync_a, sh_cfg.hs_pol);
      vsync_d  = tg_level(v_sync_a, sh_cfg.vs_pol);
      blank_d  = tg_level(!act, sh_cfg.blank_pol);
      de_d     = act;
      pix_x_d  = act ? h_offs : '0;
      pix_y_d  = act ? v_offs : '0;
      vevent_d = (hcnt == '0) && (vcnt == sh_cfg.v_event_line);
      vfetch_d = (hcnt == '0) && (vcnt == sh_cfg.v_fetch_line);
    end
  end

  // output registers; reset levels follow the default polarities
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hsync      <= tg_level(1'b0, RST_CFG.hs_pol);
      vsync      <= tg_level(1'b0, RST_CFG.vs_pol);
      blank      <= tg_level(1'b1, RST_CFG.blank_pol);
      de         <= 1'b0;
      pix_x      <= '0;
      pix_y      <= '0;
      vevent_irq <= 1'b0;
      vfetch_req <= 1'b0;
    end else begin
      hsync      <= hsync_d;
      vsync      <= vsync_d;
      blank      <= blank_d;
      de         <= de_d;
      pix_x      <= pix_x_d;
      pix_y      <= pix_y_d;
      vevent_irq <= vevent_d;
      vfetch_req <= vfetch_d;
    end
  end
endmodule

// File: rtl/disp_timing_gen_chk.sv
module disp_timing_gen_chk
  import tg_pkg::*;
(
  input logic    clk,
  input logic    rst_sync_n,
  input logic    sg_en,
  input logic    frame_wrap,
  input tg_cfg_t sh_cfg,
  input logic    blank,
  input logic    de,
  input tg_pos_t pix_x,
  input tg_pos_t pix_y,
  input logic    vevent_irq,
  input logic    vfetch_req
);
  // R4
  de_blank_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (de && $past(sg_en)) |-> (blank == !sh_cfg.blank_pol || frame_wrap || $past(frame_wrap)));

  // R5
  pix_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !de |-> (pix_x == '0 && pix_y == '0));

  // R5
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (de && $past(de) && pix_x != '0) |-> (pix_x == $past(pix_x) + tg_pos_t'(1)));

  // R6
  vevent_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vevent_irq && sh_cfg.h_total > tg_pos_t'(1)) |=> !vevent_irq);

  // R7
  vfetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vfetch_req && sh_cfg.h_total > tg_pos_t'(1)) |=> !vfetch_req);

  // R9
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(sg_en) |-> (!de && !vevent_irq && !vfetch_req && pix_x == '0 && pix_y == '0));

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sg_en && !frame_wrap) |=> $stable(sh_cfg));
endmodule

bind disp_timing_gen disp_timing_gen_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .sg_en      (sg_en),
  .frame_wrap (frame_wrap),
  .sh_cfg     (sh_cfg),
  .blank      (blank),
  .de         (de),
  .pix_x      (pix_x),
  .pix_y      (pix_y),
  .vevent_irq (vevent_irq),
  .vfetch_req (vfetch_req)
);

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;
  localparam int CLK_NS = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic sg_en;
  logic [11:0] c_hse, c_has, c_hae, c_ht, c_vse, c_vas, c_vae, c_vt, c_ev, c_fe;
  logic c_hp, c_vp, c_bp;
  logic hsync, vsync, blank, de, vevent_irq, vfetch_req;
  logic [11:0] pix_x, pix_y;

  int n_chk = 0;
  int n_fail = 0;
  bit chk_on = 1'b0;
  string phase = "R1";

  always #(CLK_NS/2) clk = ~clk;

  disp_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .sg_en(sg_en),
    .cfg_h_sync_end(c_hse), .cfg_h_act_start(c_has), .cfg_h_act_end(c_hae),
    .cfg_h_total(c_ht), .cfg_v_sync_end(c_vse), .cfg_v_act_start(c_vas),
    .cfg_v_act_end(c_vae), .cfg_v_total(c_vt), .cfg_v_event_line(c_ev),
    .cfg_v_fetch_line(c_fe), .cfg_hs_pol(c_hp), .cfg_vs_pol(c_vp),
    .cfg_blank_pol(c_bp), .hsync(hsync), .vsync(vsync), .blank(blank),
    .de(de), .pix_x(pix_x), .pix_y(pix_y), .vevent_irq(vevent_irq),
    .vfetch_req(vfetch_req)
  );

  // ---------------- reference model built from the requirements ----------
  bit m_s1, m_s2;
  int s_hse, s_has, s_hae, s_ht, s_vse, s_vas, s_vae, s_vt, s_ev, s_fe;
  bit s_hp, s_vp, s_bp;
  int mh, mv;
  bit e_hs, e_vs, e_bl, e_de, e_ev, e_fe;
  int e_px, e_py;

  task automatic m_load();
    s_hse = c_hse; s_has = c_has; s_hae = c_hae; s_ht = c_ht;
    s_vse = c_vse; s_vas = c_vas; s_vae = c_vae; s_vt = c_vt;
    s_ev = c_ev; s_fe = c_fe; s_hp = c_hp; s_vp = c_vp; s_bp = c_bp;
  endtask

  task automatic m_reset();
    s_hse = 96; s_has = 144; s_hae = 784; s_ht = 800;
    s_vse = 2; s_vas = 35; s_vae = 515; s_vt = 525;
    s_ev = 515; s_fe = 2; s_hp = 1; s_vp = 1; s_bp = 1;
    mh = 0; mv = 0;
    e_hs = 0; e_vs = 0; e_bl = 1; e_de = 0; e_px = 0; e_py = 0; e_ev = 0; e_fe = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_reset();
    end else begin
      if (!m_s2) m_reset();
      else if (!sg_en) begin
        m_load(); mh = 0; mv = 0;
        e_hs = !c_hp; e_vs = !c_vp; e_bl = c_bp; e_de = 0;
        e_px = 0; e_py = 0; e_ev = 0; e_fe = 0;
      end else begin
        bit a;
        a = (mh >= s_has) && (mh < s_hae) && (mv >= s_vas) && (mv < s_vae);
        e_hs = (mh < s_hse) ? s_hp : !s_hp;
        e_vs = (mv < s_vse) ? s_vp : !s_vp;
        e_de = a;
        e_bl = a ? !s_bp : s_bp;
        e_px = a ? (mh - s_has) : 0;
        e_py = a ? (mv - s_vas) : 0;
        e_ev = (mh == 0) && (mv == s_ev);
        e_fe = (mh == 0) && (mv == s_fe);
        if (mh >= s_ht - 1) begin
          mh = 0;
          if (mv >= s_vt - 1) begin mv = 0; m_load(); end
          else mv = mv + 1;
        end else mh = mh + 1;
      end
      m_s2 = m_s1; m_s1 = 1;
    end
  end

  task automatic check1(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      if (n_fail < 30)
        $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check1("R2/R8 hsync", hsync, e_hs);
      check1("R3/R8 vsync", vsync, e_vs);
      check1("R4 de", de, e_de);
      check1("R4/R8 blank", blank, e_bl);
      check1("R5 pix_x", pix_x, e_px);
      check1("R5 pix_y", pix_y, e_py);
      check1("R6 vevent_irq", vevent_irq, e_ev);
      check1("R7 vfetch_req", vfetch_req, e_fe);
    end
  end

  // ---------------- stimulus ----------------
  task automatic set_cfg(int hs, int hb, int ha, int hf, int vs, int vb, int va, int vf,
                         int ev, int fe, bit hp, bit vp, bit bp);
    c_hse = 12'(hs); c_has = 12'(hs + hb); c_hae = 12'(hs + hb + ha); c_ht = 12'(hs + hb + ha + hf);
    c_vse = 12'(vs); c_vas = 12'(vs + vb); c_vae = 12'(vs + vb + va); c_vt = 12'(vs + vb + va + vf);
    c_ev = 12'(ev); c_fe = 12'(fe); c_hp = hp; c_vp = vp; c_bp = bp;
  endtask

  task automatic rand_cfg();
    int hs, hb, ha, hf, vs, vb, va, vf, vt;
    hs = 1 + $urandom % 8; hb = 1 + $urandom % 8; ha = 16 + $urandom % 25; hf = 1 + $urandom % 8;
    vs = 1 + $urandom % 3; vb = 1 + $urandom % 3; va = 16 + $urandom % 5; vf = 1 + $urandom % 3;
    vt = vs + vb + va + vf;
    set_cfg(hs, hb, ha, hf, vs, vb, va, vf, $urandom % vt, $urandom % vt,
            1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_NS * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    sg_en = 1'b1;
    set_cfg(4, 4, 20, 4, 2, 2, 16, 2, 3, 1, 1'b0, 1'b0, 1'b0);
    // R1: reset levels held while rst_n is low
    run(3);
    phase = "R1";
    check1("R1 hsync", hsync, 0);
    check1("R1 vsync", vsync, 0);
    check1("R1 blank", blank, 1);
    check1("R1 de", de, 0);
    check1("R1 pix_x", pix_x, 0);
    check1("R1 vevent", vevent_irq, 0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    // R11: first frame uses built-in mode, inputs ignored
    phase = "R11";
    cnt = 0;
    while (hsync !== 1'b1 && cnt < 2000) begin @(negedge clk); cnt++; end
    cnt = 0;
    while (hsync === 1'b1 && cnt < 2000) begin @(negedge clk); cnt++; end
    check1("R11 hsync high length", cnt, 96);
    while (hsync !== 1'b1 && cnt < 4000) begin @(negedge clk); cnt++; end
    check1("R11 line period", cnt, 800);
    run(900);
    // random configurations with stop/restart and mid-frame reprogramming
    for (int i = 0; i < 8; i++) begin
      phase = "R9";
      @(negedge clk); sg_en = 1'b0;
      rand_cfg();
      run(2 + $urandom % 5);
      sg_en = 1'b1;
      phase = "R2";
      run(int'(c_ht) * int'(c_vt) + 100 + $urandom % 500);
      phase = "R10";
      rand_cfg();
      run(2 * int'(c_ht) * int'(c_vt) + 50);
    end
    // corner: zero back porch, pulses on first and last line, all active-low
    phase = "R9";
    @(negedge clk); sg_en = 1'b0;
    set_cfg(3, 0, 16, 2, 1, 0, 16, 1, 0, 17, 1'b0, 1'b0, 1'b0);
    run(3);
    sg_en = 1'b1;
    phase = "R6";
    run(2 * 21 * 18 + 10);
    // corner: stop in the middle of a frame and restart at once
    phase = "R9";
    @(negedge clk); sg_en = 1'b0;
    @(negedge clk); sg_en = 1'b1;
    run(21 * 18 + 30);
    chk_on = 1'b0;
    summary();
    $finish;
  end
endmodule